// File: doc/BRIEF.md
# Receive Queue Release Filter

This block sits beside a packet receive buffer and, for each of several queues, decides when the packet currently being written into that queue may start to flow out to the host side. It also decides whether the packet is kept or thrown away. Each queue has its own lane. A lane watches the byte count buffered so far for the current packet and an end-of-packet strobe that carries three status bits: error, runt and undersized-good. A lane is set up by a small group of per-queue control bits: a whole-packet mode, a two-bit threshold code, an enable that keeps error packets, and an enable that keeps undersized good packets.

In threshold mode a lane lets a packet start to flow once enough bytes have arrived. A packet that ends before it reaches the threshold is let out when it ends. In whole-packet mode nothing flows until the packet has been fully written.

The kept or dropped verdict is given when the packet ends. A packet that has not yet started to flow can simply be dropped. A packet that is already on its way can no longer be withdrawn, so it is flagged as bad at its end instead. The memory that holds the packets and the DMA engine that moves them belong to the surrounding logic.

Top module: `rxq_release_filter`

## Requirements
- R1: While reset is high and in the first cycle after it, every output bit is 0.
- R2: In threshold mode (whole-packet bit 0), a lane whose packet has not started flowing pulses its release bit for one cycle when the buffered count is strictly greater than the threshold and no end strobe is present. The threshold is 64 bytes for code 0, 96 bytes for code 2 and 128 bytes for code 3.
- R3: Threshold code 1 acts as 64 bytes.
- R4: When a packet ends without having started to flow and is kept, the release and forward bits pulse together in the same cycle.
- R5: With the whole-packet bit set, the buffered count and the threshold code have no effect. Release happens only at the end strobe.
- R6: A runt packet is never forwarded, whatever the keep-error enable says.
- R7: A packet with the error bit set and the runt bit clear is forwarded when keep-error is 1 and rejected when it is 0.
- R8: A packet with the undersized bit set and both error and runt clear is forwarded only when keep-undersized is 1.
- R9: A rejected packet that never started to flow gives a drop pulse with no release pulse. A rejected packet that had already started gives a bad pulse and no drop pulse.
- R10: Each lane uses only its own control bits and inputs. Lane i uses bit i of each control vector and bits [2i+1:2i] of the threshold vector.
- R11: Outputs are registered. The result of inputs sampled at a rising edge appears right after that edge and lasts one cycle.
- R12: A packet produces at most one release pulse, however many more bytes arrive before its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fill_cnt | input | NQ*CW | Bytes buffered for the current packet, CW bits per lane |
| pkt_end | input | NQ | Packet fully written; status bits are valid in this cycle |
| st_err | input | NQ | Status: packet has an error |
| st_runt | input | NQ | Status: packet is a runt |
| st_under | input | NQ | Status: packet is shorter than the minimum size but otherwise good |
| whole_pkt | input | NQ | 1 = wait for the whole packet; 0 = threshold mode |
| thr_code | input | 2*NQ | Threshold code per lane |
| keep_err | input | NQ | Forward non-runt error packets |
| keep_under | input | NQ | Forward undersized good packets |
| rel | output | NQ | One-cycle pulse: packet starts flowing to the host |
| fwd | output | NQ | One-cycle pulse at the end: packet kept |
| drop | output | NQ | One-cycle pulse at the end: packet discarded before release |
| bad | output | NQ | One-cycle pulse at the end: packet already released but rejected |

## Verification
The only internal state in a lane is the flag that records that the current packet has started to flow. If that flag is wrong, the ports show it within the same packet. If it is stuck low, a second release pulse appears on the next cycle above threshold, or a drop pulse appears where a bad pulse was due. If it fails to clear at the end strobe, the next packet shows no release pulse when it crosses the threshold. If the verdict or the threshold decode is wrong, a wrong pulse appears one cycle after the offending input. The random stimulus crosses thresholds and ends packets often enough to reach each of these cases many times per lane.

// File: rtl/rqr_pkg.sv
package rqr_pkg;

    localparam int THR_W = 8;

    typedef struct packed {
        logic err;
        logic runt;
        logic under;
    } rqr_stat_t;

    typedef struct packed {
        logic rel;
        logic fwd;
        logic drop;
        logic bad;
    } rqr_out_t;

    typedef struct packed {
        logic       whole;
        logic [1:0] code;
        logic       keep_err;
        logic       keep_under;
    } rqr_cfg_t;

    // threshold in bytes; the reserved code falls back to the smallest step
    function automatic logic [THR_W-1:0] thr_bytes(input logic [1:0] code);
        logic [THR_W-1:0] b;
        case (code)
            2'd2:    b = 8'd96;
            2'd3:    b = 8'd128;
            default: b = 8'd64;
        endcase
        return b;
    endfunction

    // 1 when a finished packet with this status should be kept
    function automatic logic keep_pkt(input rqr_stat_t s, input logic k_err,
                                      input logic k_under);
        logic k;
        if (s.runt)       k = 1'b0;
        else if (s.err)   k = k_err;
        else if (s.under) k = k_under;
        else              k = 1'b1;
        return k;
    endfunction

endpackage

// File: rtl/rqr_thr.sv
module rqr_thr
    import rqr_pkg::*;
#(
    parameter int CW = 14
) (
    input  logic [CW-1:0] fill,
    input  logic [1:0]    code,
    output logic          above
);
    localparam int XW = (CW > THR_W) ? CW : THR_W;

    logic [XW-1:0] fill_x;
    logic [XW-1:0] thr_x;

    always_comb begin
        fill_x = XW'(fill);
        thr_x  = XW'(thr_bytes(code));
        above  = fill_x > thr_x;
    end
endmodule

// File: rtl/rqr_verdict.sv
module rqr_verdict
    import rqr_pkg::*;
(
    input  rqr_stat_t stat,
    input  logic      keep_err,
    input  logic      keep_under,
    output logic      keep
);
    always_comb keep = keep_pkt(stat, keep_err, keep_under);
endmodule

// File: rtl/rqr_lane.sv
module rqr_lane
    import rqr_pkg::*;
#(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] fill,
    input  logic          pkt_end,
    input  rqr_stat_t     stat,
    input  rqr_cfg_t      cfg,
    output rqr_out_t      out
);
    logic     above;
    logic     keep;
    logic     started_q;
    logic     started_n;
    rqr_out_t out_n;

    rqr_thr #(.CW(CW)) u_thr (
        .fill  (fill),
        .code  (cfg.code),
        .above (above)
    );

    rqr_verdict u_verdict (
        .stat       (stat),
        .keep_err   (cfg.keep_err),
        .keep_under (cfg.keep_under),
        .keep       (keep)
    );

    always_comb begin
        out_n     = '0;
        started_n = started_q;
        if (pkt_end) begin
            started_n = 1'b0;
            if (!started_q) begin
                out_n.rel  = keep;
                out_n.fwd  = keep;
                out_n.drop = !keep;
            end else begin
                out_n.fwd = keep;
                out_n.bad = !keep;
            end
        end else if (!started_q && !cfg.whole && above) begin
            out_n.rel = 1'b1;
            started_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b0;
            out       <= '0;
        end else begin
            started_q <= started_n;
            out       <= out_n;
        end
    end
endmodule

// File: rtl/rxq_release_filter.sv
module rxq_release_filter
    import rqr_pkg::*;
#(
    parameter int NQ = 8,
    parameter int CW = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NQ*CW-1:0] fill_cnt,
    input  logic [NQ-1:0]   pkt_end,
    input  logic [NQ-1:0]   st_err,
    input  logic [NQ-1:0]   st_runt,
    input  logic [NQ-1:0]   st_under,
    input  logic [NQ-1:0]   whole_pkt,
    input  logic [2*NQ-1:0] thr_code,
    input  logic [NQ-1:0]   keep_err,
    input  logic [NQ-1:0]   keep_under,
    output logic [NQ-1:0]   rel,
    output logic [NQ-1:0]   fwd,
    output logic [NQ-1:0]   drop,
    output logic [NQ-1:0]   bad
);
    for (genvar q = 0; q < NQ; q++) begin : g_lane
        rqr_stat_t stat;
        rqr_cfg_t  cfg;
        rqr_out_t  o;

        always_comb begin
            stat.err       = st_err[q];
            stat.runt      = st_runt[q];
            stat.under     = st_under[q];
            cfg.whole      = whole_pkt[q];
            cfg.code       = thr_code[2*q +: 2];
            cfg.keep_err   = keep_err[q];
            cfg.keep_under = keep_under[q];
        end

        rqr_lane #(.CW(CW)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .fill    (fill_cnt[q*CW +: CW]),
            .pkt_end (pkt_end[q]),
            .stat    (stat),
            .cfg     (cfg),
            .out     (o)
        );

        assign rel[q]  = o.rel;
        assign fwd[q]  = o.fwd;
        assign drop[q] = o.drop;
        assign bad[q]  = o.bad;
    end
endmodule

// File: rtl/rxq_release_filter_chk.sv
module rxq_release_filter_chk #(
    parameter int NQ = 8,
    parameter int CW = 14
) (
    input logic            clk,
    input logic            rst,
    input logic [NQ*CW-1:0] fill_cnt,
    input logic [NQ-1:0]   pkt_end,
    input logic [NQ-1:0]   st_runt,
    input logic [NQ-1:0]   whole_pkt,
    input logic [NQ-1:0]   rel,
    input logic [NQ-1:0]   fwd,
    input logic [NQ-1:0]   drop,
    input logic [NQ-1:0]   bad
);
    for (genvar q = 0; q < NQ; q++) begin : g_chk
        AST_RUNT_NEVER_FWD: assert property (@(posedge clk) disable iff (rst)
            $past(pkt_end[q] && st_runt[q]) |-> !fwd[q]); // R6
        AST_WHOLE_REL_AT_END: assert property (@(posedge clk) disable iff (rst)
            (rel[q] && $past(whole_pkt[q])) |-> $past(pkt_end[q])); // R5
        AST_DROP_NO_REL: assert property (@(posedge clk) disable iff (rst)
            drop[q] |-> !rel[q]); // R9
        AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
            $countones({fwd[q], drop[q], bad[q]}) <= 1); // R9
        AST_VERDICT_AT_END: assert property (@(posedge clk) disable iff (rst)
            (fwd[q] || drop[q] || bad[q]) |-> $past(pkt_end[q])); // R11
        AST_REL_ABOVE_MIN: assert property (@(posedge clk) disable iff (rst)
            (rel[q] && !$past(pkt_end[q])) |-> ($past(fill_cnt[q*CW +: CW]) > CW'(64))); // R2
    end
endmodule

bind rxq_release_filter rxq_release_filter_chk #(.NQ(NQ), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fill_cnt  (fill_cnt),
    .pkt_end   (pkt_end),
    .st_runt   (st_runt),
    .whole_pkt (whole_pkt),
    .rel       (rel),
    .fwd       (fwd),
    .drop      (drop),
    .bad       (bad)
);

// File: tb/rxq_release_filter_tb.sv
module rxq_release_filter_tb;
    localparam int NQ = 8;
    localparam int CW = 14;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NQ*CW-1:0] fill_cnt = '0;
    logic [NQ-1:0]   pkt_end = '0, st_err = '0, st_runt = '0, st_under = '0;
    logic [NQ-1:0]   whole_pkt = '0, keep_err = '0, keep_under = '0;
    logic [2*NQ-1:0] thr_code = '0;
    logic [NQ-1:0]   rel, fwd, drop, bad;

    int n_chk = 0;
    int n_bad = 0;
    logic       started_m [NQ];
    logic [3:0] exp_m     [NQ];
    string      tag_m     [NQ];

    always #5 clk = ~clk;

    rxq_release_filter #(.NQ(NQ), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .fill_cnt(fill_cnt), .pkt_end(pkt_end),
        .st_err(st_err), .st_runt(st_runt), .st_under(st_under),
        .whole_pkt(whole_pkt), .thr_code(thr_code), .keep_err(keep_err),
        .keep_under(keep_under), .rel(rel), .fwd(fwd), .drop(drop), .bad(bad)
    );

    function automatic int thr_of(input logic [1:0] c);
        return (c == 2'd2) ? 96 : (c == 2'd3) ? 128 : 64;
    endfunction

    function automatic string auto_tag(input int q);
        if (pkt_end[q]) begin
            if (st_runt[q])  return "R6";
            if (st_err[q])   return "R7";
            if (st_under[q]) return "R8";
            return "R4";
        end
        if (whole_pkt[q]) return "R5";
        if (thr_code[2*q +: 2] == 2'd1) return "R3";
        return started_m[q] ? "R12" : "R2";
    endfunction

    // expected outputs from the requirements, then state update
    task automatic model(input string tag);
        for (int q = 0; q < NQ; q++) begin
            logic k;
            int   f;
            f = int'(fill_cnt[q*CW +: CW]);
            k = st_runt[q] ? 1'b0 : st_err[q] ? keep_err[q] :
                st_under[q] ? keep_under[q] : 1'b1;
            tag_m[q] = (tag == "") ? auto_tag(q) : tag;
            exp_m[q] = 4'b0000;
            if (pkt_end[q]) begin
                if (!started_m[q]) exp_m[q] = {k, k, !k, 1'b0};
                else               exp_m[q] = {1'b0, k, 1'b0, !k};
                started_m[q] = 1'b0;
            end else if (!started_m[q] && !whole_pkt[q] &&
                         f > thr_of(thr_code[2*q +: 2])) begin
                exp_m[q] = 4'b1000;
                started_m[q] = 1'b1;
            end
        end
    endtask

    task automatic compare();
        for (int q = 0; q < NQ; q++) begin
            logic [3:0] got;
            got = {rel[q], fwd[q], drop[q], bad[q]};
            n_chk++;
            if (got !== exp_m[q]) begin
                n_bad++;
                $display("FAIL %s lane %0d: got rel/fwd/drop/bad=%b expected %b",
                         tag_m[q], q, got, exp_m[q]);
            end
        end
    endtask

    // inputs are set before the call, at a falling edge
    task automatic cycle(input string tag);
        model(tag);
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        pkt_end = '0; st_err = '0; st_runt = '0; st_under = '0;
    endtask

    task automatic set_all_fill(input int f);
        for (int q = 0; q < NQ; q++) fill_cnt[q*CW +: CW] = CW'(f);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int q = 0; q < NQ; q++) begin started_m[q] = 1'b0; exp_m[q] = '0; end
        // R1: outputs held low under reset even with active inputs
        set_all_fill(200); pkt_end = '1;
        repeat (3) @(negedge clk);
        for (int q = 0; q < NQ; q++) tag_m[q] = "R1";
        compare();
        rst = 1'b0; idle(); set_all_fill(0);
        cycle("R1");

        // R2/R3/R10: lane q uses code q%4, fill equal to then above threshold
        for (int q = 0; q < NQ; q++) thr_code[2*q +: 2] = 2'(q % 4);
        whole_pkt = '0;
        for (int q = 0; q < NQ; q++) fill_cnt[q*CW +: CW] = CW'(thr_of(2'(q % 4)));
        cycle("R10");
        for (int q = 0; q < NQ; q++) fill_cnt[q*CW +: CW] = CW'(thr_of(2'(q % 4)) + 1);
        cycle("R3");
        // R12: more bytes, no second release
        set_all_fill(300);
        cycle("R12");
        cycle("R12");
        // R9: reject after release -> bad; keep_err differs per lane (R10)
        keep_err = 8'b1010_1010;
        pkt_end = '1; st_err = '1;
        cycle("R9");
        idle(); set_all_fill(0);
        cycle("R11");

        // R4/R9: short packets ending below threshold, mixed status
        set_all_fill(20);
        pkt_end = '1; st_runt = 8'b0000_0011; st_err = 8'b0000_1101;
        st_under = 8'b0011_0000; keep_err = '1; keep_under = 8'b0001_0000;
        cycle("R4");
        idle();
        cycle("R11");

        // R5: whole-packet mode ignores large fill
        whole_pkt = '1; set_all_fill(5000);
        cycle("R5");
        cycle("R5");
        pkt_end = '1;
        cycle("R5");
        idle(); set_all_fill(0);
        cycle("R5");

        // random traffic
        for (int t = 0; t < 4000; t++) begin
            if (t % 40 == 0) begin
                whole_pkt  = 8'($urandom) & 8'($urandom);
                thr_code   = 16'($urandom);
                keep_err   = 8'($urandom);
                keep_under = 8'($urandom);
            end
            for (int q = 0; q < NQ; q++) begin
                fill_cnt[q*CW +: CW] = CW'($urandom_range(0, 170));
                pkt_end[q]  = ($urandom_range(0, 5) == 0);
                st_err[q]   = ($urandom_range(0, 3) == 0);
                st_runt[q]  = ($urandom_range(0, 5) == 0);
                st_under[q] = ($urandom_range(0, 3) == 0);
            end
            cycle("");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule